// File: doc/BRIEF.md
# Bridge Doorbell Interrupt Controller

This block sits on one side of a bridge between two hosts and turns doorbell activity into interrupts for the local host. It keeps a 16-bit doorbell status register and a 16-bit mask register. Both are reachable through a small register port. The peer host rings doorbells through a dedicated ring port. Any change on the link-state input records a link event in the top status bit, bit 15. Bits 0 to 14 are ordinary doorbells.

There are two interrupt modes. In grouped mode the fifteen doorbells fold onto three vector lines of five bits each, and the link event drives a fourth line on its own. A ring in this mode lights a whole group at once. In single-interrupt mode every status bit is its own source. One combined line is raised, and a service-order output tells software which source to handle first. Software acknowledges a source by writing ones to the status register. Every output is a plain level.

Top module: `dbell_ctrl`

## Requirements
- R1: After reset the status register reads 0x0000 and the mask register reads 0x7FFF. All vector lines, the combined interrupt and the service-valid output are low.
- R2: A register write with `reg_sel`=0 clears each status bit whose write-data bit is 1. Status bits under a 0 in the write data keep their value.
- R3: A register write with `reg_sel`=1 replaces the mask register. A mask bit of 1 keeps that status bit from raising any interrupt output.
- R4: In grouped mode (`mode_single`=0), a ring with index n from 0 to 2 sets status bits 5n to 5n+4 together. A ring index of 3 or more changes nothing.
- R5: In grouped mode, `vec_irq[g]` for g from 0 to 2 is high while any unmasked set bit lies in bits 5g to 5g+4. `vec_irq[3]` is high while bit 15 is set and unmasked.
- R6: Each change of `link_up`, rising or falling, sets status bit 15 on the next clock edge. The state held at reset counts as link down.
- R7: When a ring and a status clear hit the same bit in the same cycle, the bit ends up set.
- R8: Masked bits are still recorded in the status register. Clearing the mask bit of a pending status bit raises its interrupt output right after the mask-write edge.
- R9: In single-interrupt mode (`mode_single`=1), `vec_irq` stays 0. `irq_single` is high while any unmasked status bit is set. A ring with index n from 0 to 14 sets only bit n, and index 15 changes nothing.
- R10: In single-interrupt mode, `svc_valid` equals `irq_single`. `svc_idx` reports 15 while bit 15 is set and unmasked; otherwise it reports the lowest-numbered set unmasked bit. In grouped mode, `svc_valid` and `irq_single` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_single | input | 1 | 1 selects single-interrupt mode, 0 selects grouped mode |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select for reads and writes: 0 = status, 1 = mask |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the selected register |
| ring_valid | input | 1 | Peer ring strobe |
| ring_idx | input | 4 | Doorbell or group index of the ring |
| link_up | input | 1 | Current link state |
| vec_irq | output | 4 | Grouped-mode vector levels |
| irq_single | output | 1 | Combined interrupt in single-interrupt mode |
| svc_valid | output | 1 | A source is waiting to be serviced |
| svc_idx | output | 4 | Status bit to service next |

## Verification
A table drives a ring on each group index, on an index past the last group, and on single-bit indices including the reserved link index. Each row shows whether the ring decodes into a whole group or a single bit, and whether an index out of range is dropped. Directed cases then cover partial write-one-to-clear patterns, masks that cover part of a group, unmasking a bit that is already pending, a ring colliding with a clear, and link edges in both directions. They also check that service order changes as the link bit, and then lower doorbells, are acknowledged one at a time.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  parameter int DB_W   = 16;
  parameter int GRP_W  = 5;
  parameter int VEC_N  = 4;
  localparam int NUM_GRP  = VEC_N - 1;
  localparam int LINK_BIT = DB_W - 1;
  localparam int IDX_W    = $clog2(DB_W);
  localparam logic [DB_W-1:0] MASK_RST = {1'b0, {(DB_W-1){1'b1}}};
endpackage

// File: rtl/dbell_ring_dec.sv
module dbell_ring_dec
  import dbell_pkg::*;
(
  input  logic             mode_single,
  input  logic             ring_valid,
  input  logic [IDX_W-1:0] ring_idx,
  output logic [DB_W-1:0]  ring_set
);
  logic [DB_W-1:0] grp_set;
  logic [DB_W-1:0] bit_set;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      assign grp_set[g*GRP_W +: GRP_W] =
        (ring_idx == IDX_W'(g)) ? {GRP_W{1'b1}} : '0;
    end
    if (NUM_GRP * GRP_W < DB_W) begin : g_pad
      assign grp_set[DB_W-1:NUM_GRP*GRP_W] = '0;
    end
  endgenerate

  always_comb begin
    bit_set = '0;
    if (ring_idx != IDX_W'(LINK_BIT)) bit_set[ring_idx] = 1'b1;
  end

  assign ring_set = !ring_valid ? '0 : (mode_single ? bit_set : grp_set);
endmodule

// File: rtl/dbell_link_det.sv
module dbell_link_det (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  output logic link_evt
);
  logic link_q;
  logic link_d;

  always_comb link_d = link_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_d;
  end

  assign link_evt = link_up ^ link_q;
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
  import dbell_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [DB_W-1:0] reg_wdata,
  input  logic [DB_W-1:0] set_bits,
  output logic [DB_W-1:0] stat_q,
  output logic [DB_W-1:0] mask_q
);
  logic [DB_W-1:0] stat_d;
  logic [DB_W-1:0] mask_d;
  logic [DB_W-1:0] clr_bits;
  logic            mask_en;

  always_comb begin
    clr_bits = (reg_wr && !reg_sel) ? reg_wdata : '0;
    mask_en  = reg_wr && reg_sel;
    stat_d   = (stat_q & ~clr_bits) | set_bits;
    mask_d   = mask_en ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/dbell_irq_map.sv
module dbell_irq_map
  import dbell_pkg::*;
(
  input  logic             mode_single,
  input  logic [DB_W-1:0]  stat_q,
  input  logic [DB_W-1:0]  mask_q,
  output logic [VEC_N-1:0] vec_irq,
  output logic             irq_single,
  output logic             svc_valid,
  output logic [IDX_W-1:0] svc_idx
);
  logic [DB_W-1:0] pend;
  assign pend = stat_q & ~mask_q;

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_vec
      assign vec_irq[g] = !mode_single && (|pend[g*GRP_W +: GRP_W]);
    end
  endgenerate
  assign vec_irq[VEC_N-1] = !mode_single && pend[LINK_BIT];

  assign irq_single = mode_single && (|pend);
  assign svc_valid  = irq_single;

  always_comb begin
    svc_idx = '0;
    for (int i = LINK_BIT - 1; i >= 0; i--) begin
      if (pend[i]) svc_idx = IDX_W'(i);
    end
    if (pend[LINK_BIT]) svc_idx = IDX_W'(LINK_BIT);
  end
endmodule

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
  import dbell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_single,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [DB_W-1:0]  reg_wdata,
  output logic [DB_W-1:0]  reg_rdata,
  input  logic             ring_valid,
  input  logic [IDX_W-1:0] ring_idx,
  input  logic             link_up,
  output logic [VEC_N-1:0] vec_irq,
  output logic             irq_single,
  output logic             svc_valid,
  output logic [IDX_W-1:0] svc_idx
);
  logic [DB_W-1:0] ring_set;
  logic [DB_W-1:0] set_bits;
  logic [DB_W-1:0] stat_q;
  logic [DB_W-1:0] mask_q;
  logic            link_evt;

  dbell_ring_dec u_ring (
    .mode_single (mode_single),
    .ring_valid  (ring_valid),
    .ring_idx    (ring_idx),
    .ring_set    (ring_set)
  );

  dbell_link_det u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_up  (link_up),
    .link_evt (link_evt)
  );

  always_comb begin
    set_bits           = ring_set;
    set_bits[LINK_BIT] = ring_set[LINK_BIT] | link_evt;
  end

  dbell_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .set_bits  (set_bits),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
  );

  dbell_irq_map u_map (
    .mode_single (mode_single),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .vec_irq     (vec_irq),
    .irq_single  (irq_single),
    .svc_valid   (svc_valid),
    .svc_idx     (svc_idx)
  );

  assign reg_rdata = reg_sel ? mask_q : stat_q;
endmodule

// File: rtl/dbell_ctrl_chk.sv
module dbell_ctrl_chk
  import dbell_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_single,
  input logic             ring_valid,
  input logic [IDX_W-1:0] ring_idx,
  input logic             link_up,
  input logic [VEC_N-1:0] vec_irq,
  input logic             irq_single,
  input logic             svc_valid,
  input logic [DB_W-1:0]  stat_q,
  input logic [DB_W-1:0]  mask_q
);
  AST_SINGLE_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    mode_single |-> (vec_irq == '0)); // R9

  AST_GROUPED_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_single |-> (!svc_valid && !irq_single)); // R10

  AST_RING_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_single && ring_valid && ring_idx == '0) |=> (stat_q[GRP_W-1:0] == {GRP_W{1'b1}})); // R4

  AST_LINK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && link_up != $past(link_up)) |=> stat_q[LINK_BIT]); // R6

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (vec_irq == '0 && !irq_single)); // R3
endmodule

bind dbell_ctrl dbell_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_single (mode_single),
  .ring_valid  (ring_valid),
  .ring_idx    (ring_idx),
  .link_up     (link_up),
  .vec_irq     (vec_irq),
  .irq_single  (irq_single),
  .svc_valid   (svc_valid),
  .stat_q      (stat_q),
  .mask_q      (mask_q)
);

// File: tb/dbell_ctrl_tb_top.sv
module dbell_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        mode_single;
  logic        reg_wr;
  logic        reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        ring_valid;
  logic [3:0]  ring_idx;
  logic        link_up;
  logic [3:0]  vec_irq;
  logic        irq_single;
  logic        svc_valid;
  logic [3:0]  svc_idx;

  int checks;
  int fails;

  dbell_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .mode_single (mode_single),
    .reg_wr (reg_wr), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .ring_valid (ring_valid), .ring_idx (ring_idx),
    .link_up (link_up), .vec_irq (vec_irq), .irq_single (irq_single),
    .svc_valid (svc_valid), .svc_idx (svc_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // row: {mode, idx[3:0], exp_stat[15:0], exp_vec[3:0], exp_single}
  localparam int NROW = 7;
  localparam logic [25:0] TBL [NROW] = '{
    {1'b0, 4'd0,  16'h001F, 4'b0001, 1'b0},
    {1'b0, 4'd1,  16'h03E0, 4'b0010, 1'b0},
    {1'b0, 4'd2,  16'h7C00, 4'b0100, 1'b0},
    {1'b0, 4'd3,  16'h0000, 4'b0000, 1'b0},
    {1'b1, 4'd7,  16'h0080, 4'b0000, 1'b1},
    {1'b1, 4'd14, 16'h4000, 4'b0000, 1'b1},
    {1'b1, 4'd15, 16'h0000, 4'b0000, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_sel = 1'b0; #1;
  endtask

  task automatic ring(input logic [3:0] idx);
    ring_valid = 1'b1; ring_idx = idx;
    tick();
    ring_valid = 1'b0; #1;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    reg_sel = sel; #1;
    d = reg_rdata;
    reg_sel = 1'b0; #1;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
  end

  initial begin
    logic [15:0] v;
    checks = 0; fails = 0;
    rst_n = 1'b0; mode_single = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; ring_valid = 1'b0; ring_idx = '0; link_up = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(1'b0, v); chk("R1 status", v, 16'h0000);
    rd(1'b1, v); chk("R1 mask", v, 16'h7FFF);
    chk("R1 outputs", {11'd0, vec_irq, irq_single}, 16'h0000);
    chk("R1 svc_valid", {15'd0, svc_valid}, 16'h0000);

    // Table walk: R4 R5 R9
    wr(1'b1, 16'h0000);
    for (int r = 0; r < NROW; r++) begin
      mode_single = TBL[r][25];
      wr(1'b0, 16'hFFFF);
      ring(TBL[r][24:21]);
      rd(1'b0, v);
      chk(TBL[r][25] ? "R9 ring status" : "R4 ring status", v, TBL[r][20:5]);
      chk(TBL[r][25] ? "R9 vec/single" : "R5 vec/single",
          {11'd0, vec_irq, irq_single}, {11'd0, TBL[r][4:1], TBL[r][0]});
    end
    mode_single = 1'b0;
    wr(1'b0, 16'hFFFF);

    // R2 write-one-to-clear, partial
    ring(4'd0);
    wr(1'b0, 16'h0005);
    rd(1'b0, v); chk("R2 w1c partial", v, 16'h001A);

    // R3 mask suppresses, readback
    wr(1'b1, 16'h001F);
    rd(1'b1, v); chk("R3 mask readback", v, 16'h001F);
    chk("R3 vec masked", {12'd0, vec_irq}, 16'h0000);
    // R8 still recorded, then unmask one pending bit
    rd(1'b0, v); chk("R8 masked still recorded", v, 16'h001A);
    wr(1'b1, 16'hFFFD);
    chk("R8 unmask raises vec0", {12'd0, vec_irq}, 16'h0001);

    // R7 ring collides with clear
    wr(1'b1, 16'h7FFF);
    wr(1'b0, 16'hFFFF);
    ring_valid = 1'b1; ring_idx = 4'd1;
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h03E0;
    tick();
    ring_valid = 1'b0; reg_wr = 1'b0; #1;
    rd(1'b0, v); chk("R7 set wins", v, 16'h03E0);
    wr(1'b0, 16'hFFFF);

    // R6 link rise and fall, R5 vector 3
    link_up = 1'b1;
    tick();
    rd(1'b0, v); chk("R6 link rise sets bit15", v, 16'h8000);
    chk("R5 vec3 from link", {12'd0, vec_irq}, 16'h0008);
    wr(1'b0, 16'h8000);
    rd(1'b0, v); chk("R6 steady link no event", v, 16'h0000);
    link_up = 1'b0;
    tick();
    rd(1'b0, v); chk("R6 link fall sets bit15", v, 16'h8000);

    // R10 service order in single mode
    mode_single = 1'b1;
    wr(1'b1, 16'h0000);
    ring(4'd9);
    ring(4'd3);
    chk("R10 link first", {11'd0, svc_valid, svc_idx}, 16'h001F);
    wr(1'b0, 16'h8000);
    chk("R10 lowest doorbell", {11'd0, svc_valid, svc_idx}, 16'h0013);
    wr(1'b0, 16'h0008);
    chk("R10 next doorbell", {11'd0, svc_valid, svc_idx}, 16'h0019);
    wr(1'b1, 16'h0200);
    chk("R10 masked no svc", {14'd0, svc_valid, irq_single}, 16'h0000);
    mode_single = 1'b0; #1;
    wr(1'b1, 16'h0000);
    chk("R10 grouped svc low", {14'd0, svc_valid, irq_single}, 16'h0000);
    chk("R5 vec1 in grouped", {12'd0, vec_irq}, 16'h0002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule